// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel buses, A and B, of a configurable width. Each direction passes data in one of two ways. It can forward what the opposite bus carries right now, or it can drive a value held in that direction's own storage register. Each storage register loads on the rising edge of its own capture clock. The select and output-enable inputs have no effect on loading, so either bus can be stored while the link is idle or is driving the other way. No data path inverts.

Tri-state buses cannot be synthesized, so each bus is split into separate signals. An external-drive input and its data stand for other agents on the bus. The block's own drive comes out as data plus an enable. A small keeper reports the resolved bus value and remembers it on each rising edge of a sampling clock. A bus that nobody drives therefore keeps its last value. When both directions are enabled in live mode, each side reinforces the other. This closed loop holds both buses at their last values until an outside agent drives one of them.

Top module: `bus_xcvr_reg`

## Requirements
- R1: While `rst_n` is low, both storage registers and both kept bus values are zero, asynchronously.
- R2: On a rising `clk_ab`, the A-to-B register loads the resolved A bus value. On a rising `clk_ba`, the B-to-A register loads the resolved B bus value. Both loads happen whatever the select and enable inputs are.
- R3: With `sel_ab`=0, `b_out` equals the value A presents, unmodified. With `sel_ba`=0, `a_out` equals the value B presents, unmodified.
- R4: With `sel_ab`=1, `b_out` is the A-to-B register. With `sel_ba`=1, `a_out` is the B-to-A register.
- R5: `b_oe` is high exactly when `oe_ab` is high (active-high). `a_oe` is high exactly when `oe_ba_n` is low (active-low).
- R6: Each resolved bus value is chosen in this order: the external data when its external-drive input is high, otherwise the block's own drive when enabled, otherwise the kept value.
- R7: On each rising `keep_clk`, each keeper stores its resolved bus value. A bus that no one drives therefore keeps its last value.
- R8: When both directions are enabled with both selects at 0 and neither bus is driven externally, both buses keep the values they had when the loop closed.
- R9: In that live loop, an external drive on one bus appears on the other bus. The block then drives that same value back onto the driven bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | Capture clock for the A-to-B register |
| clk_ba | input | 1 | Capture clock for the B-to-A register |
| keep_clk | input | 1 | Sampling clock of the bus keepers |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | W | Data driven onto A by an outside agent |
| a_ext | input | 1 | An outside agent drives A |
| b_in | input | W | Data driven onto B by an outside agent |
| b_ext | input | 1 | An outside agent drives B |
| sel_ab | input | 1 | B-side source: 0 live A, 1 stored |
| sel_ba | input | 1 | A-side source: 0 live B, 1 stored |
| oe_ab | input | 1 | Enable driving B, active-high |
| oe_ba_n | input | 1 | Enable driving A, active-low |
| a_out | output | W | Block drive value for A |
| a_oe | output | 1 | Block drives A |
| b_out | output | W | Block drive value for B |
| b_oe | output | 1 | Block drives B |
| a_bus | output | W | Resolved value on A |
| b_bus | output | W | Resolved value on B |

## Verification
The hardest state to reach is the self-holding loop (R8). It can only be observed if both buses already carry a known, nonzero value at the moment every external driver lets go. To get there, the stimulus first drives A from outside with both directions live, which sets up R9. It then drops the external drive and holds the loop for several keeper cycles. After that it drives B instead, to check that the loop follows the new source.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic [1:0] {
    SRC_HELD = 2'd0,
    SRC_OWN  = 2'd1,
    SRC_EXT  = 2'd2
  } bus_src_e;

  // Priority: outside agent, then own drive, then keeper
  function automatic bus_src_e pick_source(input logic ext_on, input logic own_on);
    if (ext_on)      return SRC_EXT;
    else if (own_on) return SRC_OWN;
    else             return SRC_HELD;
  endfunction

endpackage

// File: rtl/xcvr_capture_reg.sv
module xcvr_capture_reg #(
  parameter int W = 8
) (
  input  logic         cap_clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge cap_clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/xcvr_bus_keeper.sv
module xcvr_bus_keeper #(
  parameter int W = 8
) (
  input  logic         keep_clk,
  input  logic         rst_n,
  input  logic         ext_on,
  input  logic [W-1:0] ext_val,
  input  logic         own_on,
  input  logic [W-1:0] own_val,
  output logic [W-1:0] bus_val,
  output logic [W-1:0] held_val
);
  import xcvr_pkg::*;

  bus_src_e src;

  always_comb begin
    src = pick_source(ext_on, own_on);
    unique case (src)
      SRC_EXT: bus_val = ext_val;
      SRC_OWN: bus_val = own_val;
      default: bus_val = held_val;
    endcase
  end

  always_ff @(posedge keep_clk or negedge rst_n) begin
    if (!rst_n) held_val <= '0;
    else        held_val <= bus_val;
  end
endmodule

// File: rtl/xcvr_dir_path.sv
module xcvr_dir_path #(
  parameter int W = 8
) (
  input  logic         en,
  input  logic         sel,
  input  logic [W-1:0] stored,
  input  logic         src_ext,
  input  logic [W-1:0] src_in,
  input  logic [W-1:0] src_held,
  input  logic         back_en,
  input  logic         back_sel,
  input  logic [W-1:0] back_stored,
  input  logic         dst_ext,
  input  logic [W-1:0] dst_in,
  input  logic [W-1:0] dst_held,
  output logic [W-1:0] drv,
  output logic         drv_oe
);
  // Value the source bus presents, ignoring what this path itself drives
  // onto the destination (breaks the combinational loop).
  function automatic logic [W-1:0] source_view(
    input logic         s_ext,
    input logic [W-1:0] s_in,
    input logic [W-1:0] s_held,
    input logic         b_en,
    input logic         b_sel,
    input logic [W-1:0] b_stored,
    input logic         d_ext,
    input logic [W-1:0] d_in,
    input logic [W-1:0] d_held
  );
    if (s_ext)       return s_in;
    else if (!b_en)  return s_held;
    else if (b_sel)  return b_stored;
    else if (d_ext)  return d_in;
    else             return d_held;
  endfunction

  logic [W-1:0] live_val;

  always_comb begin
    live_val = source_view(src_ext, src_in, src_held, back_en, back_sel,
                           back_stored, dst_ext, dst_in, dst_held);
    drv      = sel ? stored : live_val;
    drv_oe   = en;
  end
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
  parameter int W = 8
) (
  input  logic         clk_ab,
  input  logic         clk_ba,
  input  logic         keep_clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic         a_ext,
  input  logic [W-1:0] b_in,
  input  logic         b_ext,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic         oe_ab,
  input  logic         oe_ba_n,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  output logic [W-1:0] b_out,
  output logic         b_oe,
  output logic [W-1:0] a_bus,
  output logic [W-1:0] b_bus
);
  // Named internal events for the checker
  logic         ab_en, ba_en;
  logic         pure_loop;
  logic [W-1:0] q_ab, q_ba;
  logic [W-1:0] held_a, held_b;

  assign ab_en     = oe_ab;
  assign ba_en     = ~oe_ba_n;
  assign pure_loop = ab_en & ba_en & ~sel_ab & ~sel_ba & ~a_ext & ~b_ext;

  xcvr_capture_reg #(.W(W)) u_reg_ab (
    .cap_clk(clk_ab), .rst_n(rst_n), .d(a_bus), .q(q_ab)
  );

  xcvr_capture_reg #(.W(W)) u_reg_ba (
    .cap_clk(clk_ba), .rst_n(rst_n), .d(b_bus), .q(q_ba)
  );

  xcvr_dir_path #(.W(W)) u_path_ab (
    .en(ab_en), .sel(sel_ab), .stored(q_ab),
    .src_ext(a_ext), .src_in(a_in), .src_held(held_a),
    .back_en(ba_en), .back_sel(sel_ba), .back_stored(q_ba),
    .dst_ext(b_ext), .dst_in(b_in), .dst_held(held_b),
    .drv(b_out), .drv_oe(b_oe)
  );

  xcvr_dir_path #(.W(W)) u_path_ba (
    .en(ba_en), .sel(sel_ba), .stored(q_ba),
    .src_ext(b_ext), .src_in(b_in), .src_held(held_b),
    .back_en(ab_en), .back_sel(sel_ab), .back_stored(q_ab),
    .dst_ext(a_ext), .dst_in(a_in), .dst_held(held_a),
    .drv(a_out), .drv_oe(a_oe)
  );

  xcvr_bus_keeper #(.W(W)) u_keep_a (
    .keep_clk(keep_clk), .rst_n(rst_n),
    .ext_on(a_ext), .ext_val(a_in), .own_on(a_oe), .own_val(a_out),
    .bus_val(a_bus), .held_val(held_a)
  );

  xcvr_bus_keeper #(.W(W)) u_keep_b (
    .keep_clk(keep_clk), .rst_n(rst_n),
    .ext_on(b_ext), .ext_val(b_in), .own_on(b_oe), .own_val(b_out),
    .bus_val(b_bus), .held_val(held_b)
  );
endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
  parameter int W = 8
) (
  input logic         keep_clk,
  input logic         rst_n,
  input logic         a_ext,
  input logic         b_ext,
  input logic [W-1:0] a_in,
  input logic         sel_ab,
  input logic         sel_ba,
  input logic         oe_ab,
  input logic         b_oe,
  input logic [W-1:0] b_out,
  input logic [W-1:0] a_out,
  input logic [W-1:0] a_bus,
  input logic [W-1:0] b_bus,
  input logic [W-1:0] q_ab,
  input logic [W-1:0] q_ba,
  input logic [W-1:0] held_b,
  input logic         pure_loop
);
  always_comb begin
    if (rst_n) begin
      assert_ext_wins_R6: assert (!a_ext || a_bus == a_in);
      assert_live_ab_R3:  assert (!(oe_ab && !sel_ab && a_ext) || b_bus == a_in || b_ext);
      assert_stored_ab_R4: assert (!sel_ab || b_out == q_ab);
      assert_stored_ba_R4: assert (!sel_ba || a_out == q_ba);
      assert_quiet_b_R7:  assert (b_oe || b_ext || b_bus == held_b);
    end
  end

  assert_loop_hold_R8: assert property (@(posedge keep_clk) disable iff (!rst_n)
    (pure_loop && $past(pure_loop)) |-> ($stable(a_bus) && $stable(b_bus)));

  assert_loop_follow_R9: assert property (@(posedge keep_clk) disable iff (!rst_n)
    (oe_ab && !sel_ab && !sel_ba && a_ext && !b_ext && b_oe) |-> (b_bus == a_in));
endmodule

bind bus_xcvr_reg xcvr_checker #(.W(W)) u_checker (
  .keep_clk(keep_clk), .rst_n(rst_n), .a_ext(a_ext), .b_ext(b_ext),
  .a_in(a_in), .sel_ab(sel_ab), .sel_ba(sel_ba), .oe_ab(oe_ab),
  .b_oe(b_oe), .b_out(b_out), .a_out(a_out), .a_bus(a_bus), .b_bus(b_bus),
  .q_ab(q_ab), .q_ba(q_ba), .held_b(held_b), .pure_loop(pure_loop)
);

// File: tb/test_bus_xcvr_reg.sv
module test_bus_xcvr_reg;
  localparam int W = 8;

  logic clk = 1'b0, clk_ab = 1'b0, clk_ba = 1'b0, rst_n = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic a_ext = 1'b0, b_ext = 1'b0, sel_ab = 1'b0, sel_ba = 1'b0;
  logic oe_ab = 1'b0, oe_ba_n = 1'b1;
  logic [W-1:0] a_out, b_out, a_bus, b_bus;
  logic a_oe, b_oe;

  int tests = 0, fails = 0;
  string tag = "R1";

  // behavioural reference state
  logic [W-1:0] m_rab = '0, m_rba = '0, m_ha = '0, m_hb = '0;

  always #10 clk = ~clk;  // 50 MHz

  bus_xcvr_reg #(.W(W)) i_bus_xcvr_reg (
    .clk_ab(clk_ab), .clk_ba(clk_ba), .keep_clk(clk), .rst_n(rst_n),
    .a_in(a_in), .a_ext(a_ext), .b_in(b_in), .b_ext(b_ext),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .oe_ab(oe_ab), .oe_ba_n(oe_ba_n),
    .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe),
    .a_bus(a_bus), .b_bus(b_bus)
  );

  task automatic model(output logic [W-1:0] ea, eb, ao, bo);
    bit ena = !oe_ba_n;
    bit enb = oe_ab;
    ea = m_ha; eb = m_hb;
    if (ena && enb && !sel_ab && !sel_ba && !a_ext && !b_ext) begin
      ao = m_ha; bo = m_hb;   // each side reinforces itself
    end else begin
      for (int k = 0; k < 3; k++) begin
        ea = a_ext ? a_in : (ena ? (sel_ba ? m_rba : eb) : m_ha);
        eb = b_ext ? b_in : (enb ? (sel_ab ? m_rab : ea) : m_hb);
      end
      ao = sel_ba ? m_rba : eb;
      bo = sel_ab ? m_rab : ea;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    logic [W-1:0] ea, eb, ao, bo;
    if (!rst_n) begin
      m_ha = '0; m_hb = '0; m_rab = '0; m_rba = '0;
    end else begin
      model(ea, eb, ao, bo);
      m_ha = ea; m_hb = eb;
    end
  end

  task automatic chk(string what, logic [W-1:0] act, logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    logic [W-1:0] ea, eb, ao, bo;
    model(ea, eb, ao, bo);
    chk("a_bus", a_bus, ea);
    chk("b_bus", b_bus, eb);
    chk("a_out", a_out, ao);
    chk("b_out", b_out, bo);
    chk("a_oe (R5)", {7'd0, a_oe}, {7'd0, !oe_ba_n});
    chk("b_oe (R5)", {7'd0, b_oe}, {7'd0, oe_ab});
  endtask

  // one keeper cycle: compare previous stimulus, then apply the next
  task automatic cyc(string t, logic [W-1:0] ai, logic ae, logic [W-1:0] bi, logic be,
                     logic sab, logic sba, logic oab, logic oban, bit pab, bit pba);
    logic [W-1:0] ea, eb, ao, bo;
    @(negedge clk);
    compare();
    tag = t;
    #1;
    a_in = ai; a_ext = ae; b_in = bi; b_ext = be;
    sel_ab = sab; sel_ba = sba; oe_ab = oab; oe_ba_n = oban;
    #3;
    if (pab || pba) begin
      model(ea, eb, ao, bo);
      if (pab) begin m_rab = ea; clk_ab = 1'b1; end
      if (pba) begin m_rba = eb; clk_ba = 1'b1; end
      #2;
      clk_ab = 1'b0; clk_ba = 1'b0;
    end
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    #35;
    tag = "R1";
    compare();
    chk("R1 a_bus", a_bus, 8'h00);
    @(negedge clk); rst_n = 1'b1;

    // R3: live A to B, several patterns
    cyc("R3", 8'hA5, 1, 8'h00, 0, 0, 0, 1, 1, 0, 0);
    cyc("R3", 8'h3C, 1, 8'h00, 0, 0, 0, 1, 1, 0, 0);
    cyc("R3", 8'hFF, 1, 8'h00, 0, 0, 0, 1, 1, 0, 0);
    // R3: live B to A
    cyc("R3", 8'h00, 0, 8'h96, 1, 0, 0, 0, 0, 0, 0);
    cyc("R3", 8'h00, 0, 8'h01, 1, 0, 0, 0, 0, 0, 0);
    // R2: store both with outputs disabled and selects at 1
    cyc("R2", 8'h5A, 1, 8'hC3, 1, 1, 1, 0, 1, 1, 1);
    // R7: nobody drives, buses keep last values
    cyc("R7", 8'h00, 0, 8'h00, 0, 1, 1, 0, 1, 0, 0);
    cyc("R7", 8'h00, 0, 8'h00, 0, 0, 0, 0, 1, 0, 0);
    chk("R7 a_bus kept", a_bus, 8'h5A);
    // R4: stored data onto B, then onto A
    cyc("R4", 8'h11, 1, 8'h00, 0, 1, 0, 1, 1, 0, 0);
    cyc("R4", 8'h00, 0, 8'h22, 1, 0, 1, 0, 0, 0, 0);
    cyc("R4", 8'h00, 0, 8'h00, 0, 1, 1, 1, 0, 0, 0);
    // R2: capture while driving the other way with live select
    cyc("R2", 8'h77, 1, 8'h00, 0, 0, 1, 0, 0, 1, 0);
    cyc("R4", 8'h00, 0, 8'h00, 0, 1, 0, 1, 1, 0, 0);
    @(negedge clk); #1;
    chk("R2 stored 77 on b_bus", b_bus, 8'h77);
    // R6: external beats own drive
    cyc("R6", 8'hE1, 1, 8'h1E, 1, 0, 0, 1, 0, 0, 0);
    // R9: loop with A driven from outside
    cyc("R9", 8'h6B, 1, 8'h00, 0, 0, 0, 1, 0, 0, 0);
    cyc("R9", 8'h6B, 1, 8'h00, 0, 0, 0, 1, 0, 0, 0);
    // R8: release, loop holds
    for (int i = 0; i < 5; i++) cyc("R8", 8'h00, 0, 8'h00, 0, 0, 0, 1, 0, 0, 0);
    @(negedge clk); #1;
    chk("R8 a_bus held", a_bus, 8'h6B);
    chk("R8 b_bus held", b_bus, 8'h6B);
    // R9: B driven in loop
    cyc("R9", 8'h00, 0, 8'hC4, 1, 0, 0, 1, 0, 0, 0);
    cyc("R8", 8'h00, 0, 8'h00, 0, 0, 0, 1, 0, 0, 0);
    cyc("R8", 8'h00, 0, 8'h00, 0, 0, 0, 1, 0, 0, 0);
    // R1: asynchronous reset clears registers and keepers
    @(negedge clk); compare(); #3; rst_n = 1'b0; #2;
    tag = "R1";
    a_ext = 0; b_ext = 0; sel_ab = 1; sel_ba = 1; oe_ab = 1; oe_ba_n = 0; #1;
    chk("R1 b_out stored cleared", b_out, 8'h00);
    chk("R1 a_bus cleared", a_bus, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    cyc("R1", 8'h00, 0, 8'h00, 0, 1, 1, 1, 0, 0, 0);
    @(negedge clk); compare();

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule